// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs a bank of 8-bit general-purpose I/O ports for a host that talks to it over a simple synchronous register interface. Every port has three registers. The direction register makes each pin an input or an output. The output latch holds the value that software wants to drive. A read of the data address returns the pin levels, sampled through a two-flop synchroniser, and never the latch. A pin can also carry a peripheral output. A first-level select bit chooses between the latch and a peripheral. A second-level select bit then picks one of two peripheral sources, each of which supplies a value and an enable.

Pull-up enables do not belong to single pins. Each one covers a group of four neighbouring ports, and a pin receives its pull-up only while it is an input. One pin is fixed as an input. It shares its pad with the non-maskable interrupt line, so its data bit shows that line's level. It has no usable direction bit and never gets a pull-up. When the external-bus mode input is high, a fixed set of bus-control pins is driven from the bus controller, whatever the port registers hold.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every register holds zero. All `pinOe`, `pinPullUp` and `rdData` bits read 0.
- R2: Register map:
  - Port p uses byte addresses 4p (direction), 4p+1 (data), 4p+2 (first-level select) and 4p+3 (second-level select).
  - Pin i is bit i%8 of port i/8.
  - The pull-up register sits at address 4*NUM_PORTS, and its bit g enables group g (ports 4g to 4g+3).
- R3: A pin with direction 1 and first-level select 0 has `pinOe`=1. Its `pinOut` equals the latch bit.
- R4: A data-address read returns the synchronised pin levels, not the latch. `rdData` shows a new pin level on the third rising edge after the pin changes, with the address held.
- R5: With first-level select 1 and second-level select 0, `pinOut` is `perAOut`. `pinOe` is the direction bit ANDed with `perAOe`.
- R6: With first-level select 1 and second-level select 1, the pin takes `perBOut` and `perBOe` in the same way.
- R7: `pinPullUp` is 1 exactly when all four of these hold:
  - the pin's group enable is set;
  - its direction bit is 0;
  - it is not the input-only pin;
  - it is not under bus override.
- R8: The input-only pin is port 1 bit 5.
  - Its direction bit always reads 0 and it never drives.
  - It never gets a pull-up.
  - Its data bit reads the pin level.
- R9: While `busMode` is 1, the pins in BUS_MASK (port 0 and the low nibble of port 2) take `busOut` and `busOe`, with their pull-ups off. Register writes are still accepted and take effect once `busMode` falls. Pins outside the mask are unaffected.
- R10: Addresses above the pull-up register read 0, and writes to them change nothing.
- R11: The direction, select and pull-up registers read back what was written, one cycle after the address is presented. A read made in the same cycle as a write to that register returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register byte address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| busMode | input | 1 | External-bus mode; overrides bus-control pins |
| busOut | input | 8*NUM_PORTS | Bus controller pin values |
| busOe | input | 8*NUM_PORTS | Bus controller pin enables |
| perAOut | input | 8*NUM_PORTS | Peripheral source A values |
| perAOe | input | 8*NUM_PORTS | Peripheral source A enables |
| perBOut | input | 8*NUM_PORTS | Peripheral source B values |
| perBOe | input | 8*NUM_PORTS | Peripheral source B enables |
| pinIn | input | 8*NUM_PORTS | Pad input levels |
| pinOut | output | 8*NUM_PORTS | Pad output values |
| pinOe | output | 8*NUM_PORTS | Pad output enables |
| pinPullUp | output | 8*NUM_PORTS | Pad pull-up enables |

## Verification
Two events can fall in the same cycle: a software write to the direction register of a bus-control port, and the rise of `busMode`. The bench raises `busMode` in the very cycle that it writes all ones to port 0's direction register. It then judges the pins twice. While the mode is on, the pins must follow `busOe` and `busOut` with pull-ups off, while the port 1 pull-ups stay on. Once the mode drops, the pins must show the direction value that was written during the override. A second collision is also checked: a read and a write to the pull-up register in the same cycle must return the old contents.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_DATA,
    RD_FSEL,
    RD_PSEL,
    RD_PULL
  } rdSel_e;

  // strobes from address decode to the register datapath
  typedef struct packed {
    logic   dirWr;
    logic   dataWr;
    logic   fselWr;
    logic   pselWr;
    logic   pullWr;
    logic [7:0] portIdx;
    rdSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_mux_port_ctrl.sv
module gpio_mux_port_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output portStrobe_t       strb
);

  localparam int PULL_ADDR = NUM_PORTS * 4;

  always_comb begin
    strb = '0;
    if (int'(addr) < PULL_ADDR) begin
      strb.portIdx = 8'(addr >> 2);
      unique case (addr[1:0])
        2'd0: begin strb.dirWr  = wrEn; strb.rdSel = RD_DIR;  end
        2'd1: begin strb.dataWr = wrEn; strb.rdSel = RD_DATA; end
        2'd2: begin strb.fselWr = wrEn; strb.rdSel = RD_FSEL; end
        default: begin strb.pselWr = wrEn; strb.rdSel = RD_PSEL; end
      endcase
    end else if (int'(addr) == PULL_ADDR) begin
      strb.pullWr = wrEn;
      strb.rdSel  = RD_PULL;
    end
  end

endmodule

// File: rtl/gpio_mux_port_dpath.sv
module gpio_mux_port_dpath
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS       = 8,
  parameter int PORTS_PER_GROUP = 4,
  parameter int NMI_PORT        = 1,
  parameter int NMI_BIT         = 5,
  parameter logic [NUM_PORTS*8-1:0] BUS_MASK = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  portStrobe_t            strb,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  input  logic                   busMode,
  input  logic [NUM_PORTS*8-1:0] busOut,
  input  logic [NUM_PORTS*8-1:0] busOe,
  input  logic [NUM_PORTS*8-1:0] perAOut,
  input  logic [NUM_PORTS*8-1:0] perAOe,
  input  logic [NUM_PORTS*8-1:0] perBOut,
  input  logic [NUM_PORTS*8-1:0] perBOe,
  input  logic [NUM_PORTS*8-1:0] pinIn,
  output logic [NUM_PORTS*8-1:0] pinOut,
  output logic [NUM_PORTS*8-1:0] pinOe,
  output logic [NUM_PORTS*8-1:0] pinPullUp
);

  localparam int PIN_W      = NUM_PORTS * 8;
  localparam int NUM_GROUPS = (NUM_PORTS + PORTS_PER_GROUP - 1) / PORTS_PER_GROUP;
  localparam int NMI_IDX    = NMI_PORT * 8 + NMI_BIT;
  localparam logic [PIN_W-1:0] ONLY_MASK = PIN_W'(1) << NMI_IDX;

  logic [PIN_W-1:0]      dirQ, latchQ, fselQ, pselQ;
  logic [NUM_GROUPS-1:0] pullQ;
  logic [PIN_W-1:0]      syncA, syncB;
  logic [NUM_PORTS-1:0]  portHit;
  logic [7:0]            rdNext;
  logic [PIN_W-1:0]      rawOut, rawOe, rawPull;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign portHit[p] = (strb.portIdx == 8'(p));
  end

  // register file; the input-only pin never stores a direction bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      latchQ <= '0;
      fselQ  <= '0;
      pselQ  <= '0;
      pullQ  <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (portHit[p]) begin
          if (strb.dirWr)  dirQ[p*8 +: 8]   <= wrData & ~ONLY_MASK[p*8 +: 8];
          if (strb.dataWr) latchQ[p*8 +: 8] <= wrData;
          if (strb.fselWr) fselQ[p*8 +: 8]  <= wrData;
          if (strb.pselWr) pselQ[p*8 +: 8]  <= wrData;
        end
      end
      if (strb.pullWr) pullQ <= wrData[NUM_GROUPS-1:0];
    end
  end

  // two-flop synchroniser on every pad input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    rdNext = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portHit[p]) begin
        case (strb.rdSel)
          RD_DIR:  rdNext = dirQ[p*8 +: 8];
          RD_DATA: rdNext = syncB[p*8 +: 8];
          RD_FSEL: rdNext = fselQ[p*8 +: 8];
          RD_PSEL: rdNext = pselQ[p*8 +: 8];
          default: ;
        endcase
      end
    end
    if (strb.rdSel == RD_PULL) rdNext = 8'(pullQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // per-pin output selection: bus override, then peripheral, then latch
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    localparam int GRP = (i / 8) / PORTS_PER_GROUP;
    logic override, selOut, selOe;
    assign override   = BUS_MASK[i] & busMode;
    assign selOut     = pselQ[i] ? perBOut[i] : perAOut[i];
    assign selOe      = pselQ[i] ? perBOe[i]  : perAOe[i];
    assign rawOut[i]  = override ? busOut[i] : (fselQ[i] ? selOut : latchQ[i]);
    assign rawOe[i]   = override ? busOe[i]  : (dirQ[i] & (fselQ[i] ? selOe : 1'b1));
    assign rawPull[i] = pullQ[GRP] & ~dirQ[i] & ~override;
  end

  assign pinOut    = rawOut  & ~ONLY_MASK;
  assign pinOe     = rawOe   & ~ONLY_MASK;
  assign pinPullUp = rawPull & ~ONLY_MASK;

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS       = 8,
  parameter int PORTS_PER_GROUP = 4,
  parameter int NMI_PORT        = 1,
  parameter int NMI_BIT         = 5,
  parameter logic [NUM_PORTS*8-1:0] BUS_MASK = 64'h0000_0000_000F_00FF,
  localparam int ADDR_W = $clog2(NUM_PORTS * 4 + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  input  logic                   busMode,
  input  logic [NUM_PORTS*8-1:0] busOut,
  input  logic [NUM_PORTS*8-1:0] busOe,
  input  logic [NUM_PORTS*8-1:0] perAOut,
  input  logic [NUM_PORTS*8-1:0] perAOe,
  input  logic [NUM_PORTS*8-1:0] perBOut,
  input  logic [NUM_PORTS*8-1:0] perBOe,
  input  logic [NUM_PORTS*8-1:0] pinIn,
  output logic [NUM_PORTS*8-1:0] pinOut,
  output logic [NUM_PORTS*8-1:0] pinOe,
  output logic [NUM_PORTS*8-1:0] pinPullUp
);

  portStrobe_t strb;

  gpio_mux_port_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .strb (strb)
  );

  gpio_mux_port_dpath #(
    .NUM_PORTS      (NUM_PORTS),
    .PORTS_PER_GROUP(PORTS_PER_GROUP),
    .NMI_PORT       (NMI_PORT),
    .NMI_BIT        (NMI_BIT),
    .BUS_MASK       (BUS_MASK)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .rdData   (rdData),
    .busMode  (busMode),
    .busOut   (busOut),
    .busOe    (busOe),
    .perAOut  (perAOut),
    .perAOe   (perAOe),
    .perBOut  (perBOut),
    .perBOe   (perBOe),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .pinPullUp(pinPullUp)
  );

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int NUM_PORTS       = 8,
  parameter int PORTS_PER_GROUP = 4,
  parameter int NMI_PORT        = 1,
  parameter int NMI_BIT         = 5,
  parameter logic [NUM_PORTS*8-1:0] BUS_MASK = '0,
  parameter int ADDR_W          = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      addr,
  input logic [7:0]             rdData,
  input logic                   busMode,
  input logic [NUM_PORTS*8-1:0] busOut,
  input logic [NUM_PORTS*8-1:0] busOe,
  input logic [NUM_PORTS*8-1:0] pinOut,
  input logic [NUM_PORTS*8-1:0] pinOe,
  input logic [NUM_PORTS*8-1:0] pinPullUp
);

  localparam int PULL_ADDR  = NUM_PORTS * 4;
  localparam int NUM_GROUPS = (NUM_PORTS + PORTS_PER_GROUP - 1) / PORTS_PER_GROUP;
  localparam int NMI_IDX    = NMI_PORT * 8 + NMI_BIT;

  assert_inonly_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe[NMI_IDX] && !pinPullUp[NMI_IDX]);

  assert_inonly_dir_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addr) == ADDR_W'(NMI_PORT * 4)) |-> !rdData[NMI_BIT]);

  assert_pull_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pinPullUp & pinOe) == '0);

  assert_bus_oe_R9: assert property (@(posedge clk) disable iff (!rstN)
    busMode |-> (((pinOe ^ busOe) & BUS_MASK) == '0));

  assert_bus_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    busMode |-> ((((pinOut ^ busOut) | pinPullUp) & BUS_MASK) == '0));

  assert_pull_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addr) == ADDR_W'(PULL_ADDR)) |-> ((rdData >> NUM_GROUPS) == 8'd0));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (int'($past(addr)) > PULL_ADDR) |-> (rdData == 8'd0));

endmodule

bind gpio_mux_port gpio_mux_port_chk #(
  .NUM_PORTS      (NUM_PORTS),
  .PORTS_PER_GROUP(PORTS_PER_GROUP),
  .NMI_PORT       (NMI_PORT),
  .NMI_BIT        (NMI_BIT),
  .BUS_MASK       (BUS_MASK),
  .ADDR_W         (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .rdData   (rdData),
  .busMode  (busMode),
  .busOut   (busOut),
  .busOe    (busOe),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .pinPullUp(pinPullUp)
);

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        busMode = 1'b0;
  logic [63:0] busOut = '0, busOe = '0;
  logic [63:0] perAOut = '0, perAOe = '0, perBOut = '0, perBOe = '0;
  logic [63:0] pinIn = '0;
  logic [63:0] pinOut, pinOe, pinPullUp;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .busMode(busMode), .busOut(busOut), .busOe(busOe),
    .perAOut(perAOut), .perAOe(perAOe), .perBOut(perBOut), .perBOe(perBOe),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pinPullUp(pinPullUp)
  );

  typedef struct packed {
    logic [5:0] a;
    logic [7:0] w;
    logic [7:0] e;
  } vec_t;

  // write, then read back: address, write value, expected read
  localparam vec_t VECS [10] = '{
    '{6'd0,  8'hFF, 8'hFF},  // R11 direction port 0
    '{6'd2,  8'h5A, 8'h5A},  // R11 first-level select port 0
    '{6'd3,  8'h3C, 8'h3C},  // R11 second-level select port 0
    '{6'd4,  8'hFF, 8'hDF},  // R8 input-only direction bit stays 0
    '{6'd32, 8'hFF, 8'h03},  // R11 pull-up register, two groups
    '{6'd33, 8'hFF, 8'h00},  // R10 unmapped
    '{6'd63, 8'h12, 8'h00},  // R10 unmapped
    '{6'd1,  8'h77, 8'h00},  // R4 data read shows pins, not latch
    '{6'd0,  8'h00, 8'h00},  // R11
    '{6'd32, 8'h00, 8'h00}   // R11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    addr = a; wrEn = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 oe", pinOe, 64'h0);
    check("R1 pull", pinPullUp, 64'h0);
    check("R1 rd", {56'h0, rdData}, 64'h0);

    for (int k = 0; k < 10; k++) begin
      wr(VECS[k].a, VECS[k].w);
      rd(VECS[k].a);
      check("R2/R4/R8/R10/R11 vector", {56'h0, rdData}, {56'h0, VECS[k].e});
    end

    // R3 plain output from latch on port 3
    wr(6'd12, 8'hF0);
    wr(6'd13, 8'hA5);
    check("R3 oe", {56'h0, pinOe[31:24]}, 64'hF0);
    check("R3 out", {56'h0, pinOut[31:24]}, 64'hA5);

    // R4 synchroniser latency on port 3
    addr = 6'd13; pinIn[31:24] = 8'h3C;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    check("R4 before sync", {56'h0, rdData}, 64'h00);
    @(posedge clk); @(negedge clk);
    check("R4 after sync", {56'h0, rdData}, 64'h3C);

    // R5 / R6 peripheral selection on port 4
    perAOut = {8{8'h55}}; perAOe = {8{8'hFB}};
    perBOut = {8{8'hAA}}; perBOe = {8{8'hFF}};
    wr(6'd16, 8'hFF);
    wr(6'd17, 8'hC0);
    wr(6'd18, 8'h0F);
    wr(6'd19, 8'h03);
    check("R5/R6 out", {56'h0, pinOut[39:32]}, 64'hC6);
    check("R5/R6 oe", {56'h0, pinOe[39:32]}, 64'hFB);

    // R7 grouped pull-ups
    wr(6'd4, 8'h00);
    wr(6'd20, 8'h0F);
    wr(6'd32, 8'h02);
    check("R7 port5", {56'h0, pinPullUp[47:40]}, 64'hF0);
    check("R7 port4", {56'h0, pinPullUp[39:32]}, 64'h00);
    check("R7 group0 off", {56'h0, pinPullUp[15:8]}, 64'h00);
    wr(6'd32, 8'h01);
    check("R7 port1", {56'h0, pinPullUp[15:8]}, 64'hDF);

    // R8 input-only pin
    wr(6'd4, 8'hFF);
    check("R8 oe", {56'h0, pinOe[15:8]}, 64'hDF);
    check("R8 pull", {56'h0, pinPullUp[15:8]}, 64'h00);
    pinIn[13] = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rd(6'd5);
    check("R8 level", {56'h0, rdData}, 64'h20);
    wr(6'd4, 8'h00);

    // R9 bus override colliding with a direction write
    busOut = {8{8'h5A}}; busOe = {8{8'h33}};
    wr(6'd8, 8'hF0);
    wr(6'd9, 8'hFF);
    busMode = 1'b1;
    wr(6'd0, 8'hFF);
    check("R9 oe p0", {56'h0, pinOe[7:0]}, 64'h33);
    check("R9 out p0", {56'h0, pinOut[7:0]}, 64'h5A);
    check("R9 oe p2", {56'h0, pinOe[23:16]}, 64'hF3);
    check("R9 out p2", {56'h0, pinOut[23:16]}, 64'hFA);
    check("R9 pull p0", {56'h0, pinPullUp[7:0]}, 64'h00);
    check("R9 pull p1 kept", {56'h0, pinPullUp[15:8]}, 64'hDF);
    busMode = 1'b0;
    @(negedge clk);
    check("R9 write took", {56'h0, pinOe[7:0]}, 64'hFF);

    // R11 read and write of the same register in one cycle
    addr = 6'd32; wrData = 8'h00; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    check("R11 old value", {56'h0, rdData}, 64'h01);
    @(posedge clk); @(negedge clk);
    check("R11 new value", {56'h0, rdData}, 64'h00);

    // R10 unmapped write has no effect
    wr(6'd40, 8'hFF);
    rd(6'd40);
    check("R10 read", {56'h0, rdData}, 64'h00);
    rd(6'd32);
    check("R10 pull kept", {56'h0, rdData}, 64'h00);
    rd(6'd0);
    check("R10 dir kept", {56'h0, rdData}, 64'hFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule